// File: doc/BRIEF.md
# Nesting Global Interrupt Controller

This block gathers ten peripheral interrupt request lines, holds each one in a pending latch, and offers the highest-numbered pending and enabled source to a CPU. The CPU sees a request line and a 4-bit vector index. It accepts the interrupt with an acknowledge pulse. A register bus holds a per-source enable mask. The bus also has two write-only strobe addresses and a readable counter. Together these form a global masking mechanism that can nest.

Global masking uses a saturating 4-bit nesting counter rather than a single enable flag. A write to one address raises the count and a write to another lowers it. Any nonzero count blocks every source. Accepting an interrupt raises the count by itself, so a handler must lower it again before it returns. Any change to the effective mask, whether from the enable register or from the counter, reaches delivery through a fixed delay line of six clock cycles. This makes the masking latency exact and repeatable.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A bus write to address 0 stores `bus_wdata[9:0]` as the enable mask, which reads back at address 0. Bit n enables source n. The bit assignment is 0 audio output converter, 1 control port, 2 data port, 3 audio input converter, 4 serial transmit, 5 serial receive, 6 timer 0, 7 timer 1, 8 rate converter, 9 side-channel modulator.
- R2: A bus write of any value to address 1 adds one to the nesting counter, and the counter holds at 15 rather than wrapping.
- R3: A bus write of any value to address 2 subtracts one from the counter, and it leaves the counter unchanged when the counter is already 0.
- R4: While the counter is nonzero no interrupt is delivered. Once it is back at 0, enabled pending sources are delivered again.
- R5: An accepted interrupt (`cpu_ack` high while `cpu_irq` is high) adds one to the counter. When it coincides with a write to address 1, the counter rises by two, still saturating at 15.
- R6: A change of the effective mask (enable register or counter) affects `cpu_irq` exactly six clock edges after the edge that made the change, and not earlier.
- R7: A one-cycle pulse on `src_req[n]` sets pending bit n. The bit stays set, even while the source is disabled or masked, until that source is accepted.
- R8: Among sources that are both pending and passing the delayed mask, the highest index is presented on `cpu_vec`, with `cpu_irq` high.
- R9: Acceptance clears only the pending bit of the presented source. `cpu_ack` while `cpu_irq` is low changes neither the pending bits nor the counter.
- R10: After reset the enable mask, the counter and all pending bits are zero and `cpu_irq` is low.
- R11: A read at address 3 returns the counter in bits 3:0 with the upper bits zero. Reads at addresses 1 and 2 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 enable, 1 mask raise, 2 mask lower, 3 counter |
| bus_wdata | input | 10 | Write data (used at address 0 only) |
| bus_rdata | output | 10 | Read data for `bus_addr` |
| src_req | input | 10 | Per-source request pulses |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_vec | output | 4 | Index of the presented source |
| cpu_ack | input | 1 | CPU acceptance pulse |

## Verification
The bench aims at the exact edge on which a mask change lands. A pipeline one stage short or long would raise the request a cycle early or late. It lowers the counter at zero, where a design without the floor would wrap to 15 and mask everything. It pushes the counter past 15, where a wrapping design would return to 0 and unmask. It acknowledges during the six-cycle window after entry, where a second source is still visible, which exposes a design that clears the wrong pending bit or one that treats an acknowledge with no request as an entry. It also drives acceptance and a mask-raise write in the same cycle, which a design that drops one of the two increments gets wrong.

// File: rtl/nic_pkg.sv
// Shared definitions for the nesting interrupt controller.
// Assumes a 2-bit register address space.
package nic_pkg;

    // Register address map
    typedef enum logic [1:0] {
        ADR_ENABLE = 2'd0,
        ADR_RAISE  = 2'd1,
        ADR_LOWER  = 2'd2,
        ADR_COUNT  = 2'd3
    } nic_addr_e;

    // Source numbering; the arbiter favours the higher index
    localparam int SRC_DAC_OUT  = 0;
    localparam int SRC_CTRL     = 1;
    localparam int SRC_DATA     = 2;
    localparam int SRC_ADC_IN   = 3;
    localparam int SRC_SER_TX   = 4;
    localparam int SRC_SER_RX   = 5;
    localparam int SRC_TIMER0   = 6;
    localparam int SRC_TIMER1   = 7;
    localparam int SRC_RATECONV = 8;
    localparam int SRC_SIDEMOD  = 9;

endpackage

// File: rtl/nic_regs.sv
// Register file: enable mask plus the saturating nesting counter.
// Assumes at most one bus write per cycle. Acceptance and a bus strobe
// may coincide, and their increments add. A lower strobe only acts
// when the counter was nonzero before the edge.
module nic_regs #(
    parameter int NSRC = 10,
    parameter int CNTW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [1:0]      bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    input  logic            accept,
    output logic [NSRC-1:0] enable_q,
    output logic [CNTW-1:0] count_q,
    output logic [NSRC-1:0] bus_rdata
);
    import nic_pkg::*;

    localparam int SUMW = CNTW + 2;
    localparam logic [SUMW-1:0] CNT_MAX = SUMW'((1 << CNTW) - 1);

    logic            en_wr;
    logic            raise_wr;
    logic            lower_wr;
    logic            lower_ok;
    logic [SUMW-1:0] sum;
    logic [CNTW-1:0] count_d;

    // Decode the bus strobes
    always_comb begin
        en_wr    = bus_we && (nic_addr_e'(bus_addr) == ADR_ENABLE);
        raise_wr = bus_we && (nic_addr_e'(bus_addr) == ADR_RAISE);
        lower_wr = bus_we && (nic_addr_e'(bus_addr) == ADR_LOWER);
        lower_ok = lower_wr && (count_q != '0);
    end

    // Next counter value: add raises, drop lowers, clip at the top
    always_comb begin
        sum = SUMW'(count_q) + SUMW'(raise_wr) + SUMW'(accept) - SUMW'(lower_ok);
        if (sum > CNT_MAX) begin
            count_d = CNT_MAX[CNTW-1:0];
        end else begin
            count_d = sum[CNTW-1:0];
        end
    end

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (en_wr) begin
            enable_q <= bus_wdata;
        end
    end

    // Nesting counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    // Read mux
    always_comb begin
        case (nic_addr_e'(bus_addr))
            ADR_ENABLE: bus_rdata = enable_q;
            ADR_COUNT:  bus_rdata = NSRC'(count_q);
            default:    bus_rdata = '0;
        endcase
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX[CNTW-1:0] && raise_wr) |=> (count_q == CNT_MAX[CNTW-1:0])); // R2
    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && lower_wr && !accept) |=> (count_q == '0)); // R3
    AST_ACCEPT_BUMPS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !bus_we && count_q != CNT_MAX[CNTW-1:0]) |=> (count_q == $past(count_q) + 1'b1)); // R5
    AST_RAISE_BUMPS: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_wr && !accept && count_q != CNT_MAX[CNTW-1:0]) |=> (count_q == $past(count_q) + 1'b1)); // R2

endmodule

// File: rtl/nic_mask_pipe.sv
// Fixed-latency delay line for the effective source mask.
// Assumes LAT >= 1. Every change of the effective mask reaches the
// output exactly LAT edges after it appears at the input. Resets to
// all-blocked.
module nic_mask_pipe #(
    parameter int NSRC = 10,
    parameter int LAT  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] mask_in,
    output logic [NSRC-1:0] mask_out
);
    logic [NSRC-1:0] stg [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_head
            // First stage samples the live mask
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= mask_in;
            end
        end else begin : g_body
            // Later stages shift the mask one cycle along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign mask_out = stg[LAT-1];

endmodule

// File: rtl/nic_pending.sv
// Pending latches, one per source.
// Assumes that clr is at most one-hot. A new request in the same cycle
// as the clear of that source wins, so the request is not lost.
module nic_pending #(
    parameter int NSRC = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend_q
);
    // Set on request, drop on acceptance of that source
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | src_req;
    end

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(clr)) & ~pend_q) == '0)); // R7
    AST_PEND_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr)); // R9

endmodule

// File: rtl/nic_arbiter.sv
// Fixed-priority selector: the highest set bit of the request vector
// wins. Purely combinational. Assumes NSRC <= 2**IDXW.
module nic_arbiter #(
    parameter int NSRC = 10,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    output logic            any,
    output logic [IDXW-1:0] idx,
    output logic [NSRC-1:0] grant
);
    // Scan upward so the last hit is the highest index
    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i]) idx = IDXW'(i);
        end
        any   = |req;
        grant = any ? (NSRC'(1) << idx) : '0;
    end

    AST_WINNER_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((req >> (idx + 1'b1)) == '0 && req[idx])); // R8

endmodule

// File: rtl/nest_irq_ctrl.sv
// Nesting global interrupt controller top.
// Assumes one bus access per cycle and single-cycle request and
// acknowledge pulses. Outputs are combinational from registers. An
// acknowledge only counts while cpu_irq is high, and it retires the
// presented source.
module nest_irq_ctrl #(
    parameter int NSRC = 10,
    parameter int CNTW = 4,
    parameter int LAT  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [1:0]      bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    input  logic [NSRC-1:0] src_req,
    output logic            cpu_irq,
    output logic [$clog2(NSRC)-1:0] cpu_vec,
    input  logic            cpu_ack
);
    localparam int IDXW = $clog2(NSRC);
    localparam int RUNW = $clog2(LAT + 1);

    logic [NSRC-1:0] enable_q;
    logic [CNTW-1:0] count_q;
    logic [NSRC-1:0] eff_mask;
    logic [NSRC-1:0] mask_d;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] grant;
    logic [NSRC-1:0] clr;
    logic            accept;
    logic [RUNW-1:0] blk_run;

    nic_regs #(.NSRC(NSRC), .CNTW(CNTW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .accept    (accept),
        .enable_q  (enable_q),
        .count_q   (count_q),
        .bus_rdata (bus_rdata)
    );

    // Live mask: enabled sources, but only while the counter is zero
    always_comb eff_mask = (count_q == '0) ? enable_q : '0;

    nic_mask_pipe #(.NSRC(NSRC), .LAT(LAT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_in  (eff_mask),
        .mask_out (mask_d)
    );

    nic_pending #(.NSRC(NSRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_req (src_req),
        .clr     (clr),
        .pend_q  (pend_q)
    );

    nic_arbiter #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (pend_q & mask_d),
        .any   (cpu_irq),
        .idx   (cpu_vec),
        .grant (grant)
    );

    // Acceptance handshake and the pending clear it causes
    always_comb begin
        accept = cpu_ack && cpu_irq;
        clr    = accept ? grant : '0;
    end

    // Checker-side count of consecutive cycles with a nonzero counter
    always_ff @(posedge clk) begin
        if (!rst_n)                       blk_run <= '0;
        else if (count_q == '0)           blk_run <= '0;
        else if (blk_run < RUNW'(LAT))    blk_run <= blk_run + 1'b1;
    end

    AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_run == RUNW'(LAT)) |-> !cpu_irq); // R4
    AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !cpu_irq && !bus_we) |=> $stable(count_q)); // R9
    AST_IRQ_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> pend_q[cpu_vec]); // R7

endmodule

// File: tb/nest_irq_ctrl_test.sv
// Bench: a behavioural reference model updated on every edge and
// compared after every falling edge, plus directed corner checks.
module nest_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [9:0] bus_wdata = '0;
    logic [9:0] bus_rdata;
    logic [9:0] src_req = '0;
    logic       cpu_irq;
    logic [3:0] cpu_vec;
    logic       cpu_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    // Reference model state
    logic [9:0] m_en, m_pend;
    int         m_cnt;
    logic [9:0] mq[$];

    always #4 clk = ~clk;

    nest_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
        .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack)
    );

    function automatic logic [9:0] m_live();
        return m_pend & mq[0];
    endfunction

    function automatic int m_top(logic [9:0] v);
        int w = 0;
        for (int i = 0; i < 10; i++) if (v[i]) w = i;
        return w;
    endfunction

    // Model update on each rising edge, using pre-edge state
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_pend = '0; m_cnt = 0;
            mq.delete();
            for (int i = 0; i < 6; i++) mq.push_back('0);
        end else begin
            logic [9:0] live, eff;
            bit acc;
            int up, dn, vec;
            live = m_live();
            acc  = cpu_ack && (live != 0);
            vec  = m_top(live);
            eff  = (m_cnt == 0) ? m_en : '0;
            up   = (bus_we && bus_addr == 2'd1) + acc;
            dn   = (bus_we && bus_addr == 2'd2 && m_cnt > 0) ? 1 : 0;
            if (bus_we && bus_addr == 2'd0) m_en = bus_wdata;
            m_cnt = m_cnt + up - dn;
            if (m_cnt > 15) m_cnt = 15;
            if (acc) m_pend[vec] = 1'b0;
            m_pend = m_pend | src_req;
            mq.push_back(eff);
            void'(mq.pop_front());
        end
    end

    function automatic logic [9:0] m_rdata();
        case (bus_addr)
            2'd0:    return m_en;
            2'd3:    return 10'(m_cnt);
            default: return '0;
        endcase
    endfunction

    // Cycle compare, away from both clock edges
    always @(negedge clk) begin
        #2;
        if (rst_n && mq.size() == 6) begin
            logic [9:0] live;
            live = m_live();
            checks++;
            if (cpu_irq !== (live != 0)) begin
                fails++;
                $display("FAIL R4 cycle irq actual=%0b expected=%0b", cpu_irq, live != 0);
            end
            if (live != 0) begin
                checks++;
                if (cpu_vec !== 4'(m_top(live))) begin
                    fails++;
                    $display("FAIL R8 cycle vec actual=%0d expected=%0d", cpu_vec, m_top(live));
                end
            end
            checks++;
            if (bus_rdata !== m_rdata()) begin
                fails++;
                $display("FAIL R11 cycle rdata actual=%h expected=%h", bus_rdata, m_rdata());
            end
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic expect_eq(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [9:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, int exp, string tag);
        bus_addr = a;
        #1;
        expect_eq(int'(bus_rdata), exp, tag);
    endtask

    task automatic pulse(logic [9:0] m);
        src_req = m;
        tick();
        src_req = '0;
    endtask

    task automatic take();
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R10 reset state
        expect_eq(cpu_irq, 0, "R10 irq after reset");
        rd(2'd0, 0, "R10 enable after reset");
        rd(2'd3, 0, "R10 counter after reset");

        // R7: request on a disabled source stays pending, not delivered
        pulse(10'h020);
        repeat (8) tick();
        expect_eq(cpu_irq, 0, "R7 disabled source held back");

        // R6: enable lands exactly six edges later
        wr(2'd0, 10'h020);
        for (int i = 0; i < 6; i++) begin
            expect_eq(cpu_irq, 0, "R6 too early");
            tick();
        end
        expect_eq(cpu_irq, 1, "R6 on time");
        expect_eq(cpu_vec, 5, "R7 pending kept vec");

        // R5 acceptance raises counter; R9 clears presented source
        take();
        expect_eq(cpu_irq, 0, "R9 source retired");
        rd(2'd3, 1, "R5 counter after accept");
        take();
        rd(2'd3, 1, "R9 idle ack ignored");

        // R4 blocking and R3 lowering
        pulse(10'h004);
        wr(2'd0, 10'h3FF);
        rd(2'd0, 10'h3FF, "R1 enable readback");
        repeat (10) tick();
        expect_eq(cpu_irq, 0, "R4 blocked while nonzero");
        wr(2'd2, 10'h000);
        rd(2'd3, 0, "R3 lowered");
        repeat (7) tick();
        expect_eq(cpu_irq, 1, "R4 restored");
        expect_eq(cpu_vec, 2, "R4 vec");

        // R8 priority, R9 during the latency window
        take();
        pulse(10'h090);
        expect_eq(cpu_vec, 7, "R8 highest wins");
        take();
        expect_eq(cpu_irq, 1, "R9 window irq");
        expect_eq(cpu_vec, 4, "R9 only presented cleared");
        repeat (6) tick();
        expect_eq(cpu_irq, 0, "R4 nested block");
        rd(2'd3, 2, "R5 two entries");
        wr(2'd2, 10'h000);
        wr(2'd2, 10'h000);
        repeat (7) tick();
        expect_eq(cpu_vec, 4, "R4 vec after unnest");
        take();
        wr(2'd2, 10'h000);
        wr(2'd2, 10'h000);
        rd(2'd3, 0, "R3 floor at zero");

        // R2 saturation
        for (int i = 0; i < 17; i++) wr(2'd1, 10'h155);
        rd(2'd3, 15, "R2 saturated");
        wr(2'd2, 10'h000);
        rd(2'd3, 14, "R3 lower from 15");
        rd(2'd1, 0, "R11 raise addr reads zero");
        rd(2'd2, 0, "R11 lower addr reads zero");
        for (int i = 0; i < 14; i++) wr(2'd2, 10'h000);

        // R5 acceptance together with a raise write
        pulse(10'h001);
        repeat (7) tick();
        expect_eq(cpu_vec, 0, "R8 lowest alone");
        bus_we = 1'b1; bus_addr = 2'd1; cpu_ack = 1'b1;
        tick();
        bus_we = 1'b0; cpu_ack = 1'b0;
        rd(2'd3, 2, "R5 accept plus raise");
        wr(2'd2, 10'h000);
        wr(2'd2, 10'h000);

        // Mixed traffic compared against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            src_req  = (lfsr[2:0] == 3'd0) ? (lfsr[12:3] & lfsr[22:13]) : '0;
            cpu_ack  = lfsr[23];
            bus_addr = lfsr[25:24];
            bus_wdata = lfsr[31:22];
            case (lfsr[28:26])
                3'd0:       bus_we = (lfsr[29] && lfsr[30]);
                3'd1:       bus_we = 1'b0;
                3'd2, 3'd3: begin bus_we = 1'b1; bus_addr = 2'd2; end
                3'd4:       begin bus_we = lfsr[30]; bus_addr = 2'd1; end
                default:    bus_we = 1'b0;
            endcase
            tick();
        end
        bus_we = 1'b0; cpu_ack = 1'b0; src_req = '0;
        tick();
        summary();
        $finish;
    end

endmodule